// File: doc/BRIEF.md
# Fractional-Divided PWM Timer Counter

This block is the time base of a PWM generator. It picks one of two tick-enable sources, a slow one and a reference one, and divides that source by a fixed-point divisor that carries a fractional part. The divided ticks drive a counter that runs from zero up to a top value set by a resolution field. When the counter wraps back to zero, a one-cycle pulse is raised. Comparator and duty-cycle logic sit downstream and read the counter value.

The divisor and resolution inputs work like register fields. A new divisor or resolution is held in a shadow copy until an update strobe arrives. The shadow copy is then moved into the working copy at the end of the divided period in progress, so a period is never cut short. The fractional part of the divisor is handled by a phase accumulator. Whenever the accumulator carries out, the next period is stretched by one source tick, so the long-run average period equals the full divisor. A pause input freezes the counter. A clear input restarts the counter, and clear wins over pause.

Top module: `frac_pwm_timer`

## Requirements
- R1: After reset, `count` is 0 and `wrap` is 0. The working divisor is 1.0 and the working resolution is `INIT_RES`, so the block counts without any configuration being loaded.
- R2: `src_sel` chooses the counting source. At 0, a cycle with `slow_tick` high is one source tick. At 1, a cycle with `ref_tick` high is one source tick. The source that is not selected has no effect.
- R3: `div_val` is fixed-point, and its low `FRAC_W` bits are the fraction. Let I be the integer part and F the fraction field, and count source ticks from a clear. Then the k-th divided tick, which advances `count`, falls on source tick k·I + floor((k−1)·F / 2^FRAC_W).
- R4: A divisor with integer part 0 is treated as exactly 1.0, so every source tick advances `count`.
- R5: With effective resolution r, `count` steps 0, 1, …, 2^r − 1 and then back to 0. A `res_val` of 0 acts as 1, and a value above `MAX_RES` acts as `MAX_RES`.
- R6: `wrap` is high for exactly the one cycle in which `count` has just returned to 0 from its top value, and it is low at all other times.
- R7: Values on `div_val` and `res_val` have no effect until `cfg_update` is pulsed. After the pulse, they take effect at the end of the divided period already in progress. That period keeps its old length.
- R8: While `pause` is high, `count` holds its value, `wrap` stays low, and source ticks are ignored by the divider. Division resumes from the same point once `pause` drops.
- R9: A cycle with `clear` high sets `count` to 0 and restarts the divider with the phase accumulator at 0. `clear` takes priority over `pause`. A pending update, or one strobed in the same cycle, is loaded at once.
- R10: Between consecutive cycles, `count` either holds, rises by exactly one, or returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow-source tick enable |
| ref_tick | input | 1 | Reference-source tick enable |
| src_sel | input | 1 | Source select: 0 slow, 1 reference |
| div_val | input | INT_W+FRAC_W | Divisor to load: integer part in the high bits, fraction in the low FRAC_W bits |
| res_val | input | RES_W | Counter resolution to load, in bits |
| cfg_update | input | 1 | One-cycle strobe that takes in `div_val` and `res_val` |
| pause | input | 1 | Freeze the counter and the divider |
| clear | input | 1 | Restart the counter and the divider |
| count | output | MAX_RES | Timer counter value |
| wrap | output | 1 | One-cycle pulse when the counter wraps to 0 |

## Verification
The bench builds the block with a 3-bit integer part, a 4-bit fraction, a 3-bit resolution field, a maximum resolution of 6 and an initial resolution of 2. This makes the divisor only 7 bits wide, so every one of its 128 values is swept. For each value the bench checks the exact source tick of every divided tick against the closed-form formula, including the values below 1.0. The small resolution field also lets the bench walk every field value from 0 to 7, covering both clamps and full count cycles up to the 64-step top. Directed runs cover deferred updates in the middle of a period, pause part-way through a period, clear combined with pause, and clearing of the phase accumulator.

// File: rtl/frac_pwm_timer.sv
module frac_pwm_timer #(
  parameter int INT_W    = 10,
  parameter int FRAC_W   = 8,
  parameter int RES_W    = 5,
  parameter int MAX_RES  = 20,
  parameter int INIT_RES = 8,
  localparam int DIV_W   = INT_W + FRAC_W,
  localparam int CNT_W   = MAX_RES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             ref_tick,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic [RES_W-1:0] res_val,
  input  logic             cfg_update,
  input  logic             pause,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  logic [DIV_W-1:0]  act_div, shd_div;
  logic [RES_W-1:0]  act_res, shd_res;
  logic              pend;
  logic [INT_W:0]    tick_cnt;
  logic [FRAC_W-1:0] phase;
  logic              extra;

  logic              below_one;
  logic [INT_W-1:0]  int_eff;
  logic [FRAC_W-1:0] frac_eff;
  logic [INT_W:0]    per_m1;
  logic [FRAC_W-1:0] phase_nxt;
  logic              carry;
  logic [RES_W-1:0]  res_eff;
  logic [RES_W-1:0]  shamt;
  logic [CNT_W-1:0]  top;
  logic              src_tick, run, last, at_top, load_now;
  logic [DIV_W-1:0]  load_div;
  logic [RES_W-1:0]  load_res;

  assign src_tick  = src_sel ? ref_tick : slow_tick;
  assign run       = src_tick && !pause && !clear;

  assign below_one = (act_div[DIV_W-1:FRAC_W] == '0);
  assign int_eff   = below_one ? INT_W'(1) : act_div[DIV_W-1:FRAC_W];
  assign frac_eff  = below_one ? '0 : act_div[FRAC_W-1:0];
  assign per_m1    = {1'b0, int_eff} + {{INT_W{1'b0}}, extra} - (INT_W+1)'(1);
  assign last      = (tick_cnt == per_m1);
  assign {carry, phase_nxt} = {1'b0, phase} + {1'b0, frac_eff};

  assign res_eff   = (act_res == '0) ? RES_W'(1) :
                     (act_res > RES_W'(MAX_RES)) ? RES_W'(MAX_RES) : act_res;
  assign shamt     = RES_W'(MAX_RES) - res_eff;
  assign top       = {CNT_W{1'b1}} >> shamt;
  assign at_top    = (count >= top);

  assign load_now  = pend || cfg_update;
  assign load_div  = cfg_update ? div_val : shd_div;
  assign load_res  = cfg_update ? res_val : shd_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div  <= DIV_W'(1) << FRAC_W;
      act_res  <= RES_W'(INIT_RES);
      shd_div  <= DIV_W'(1) << FRAC_W;
      shd_res  <= RES_W'(INIT_RES);
      pend     <= 1'b0;
      tick_cnt <= '0;
      phase    <= '0;
      extra    <= 1'b0;
      count    <= '0;
      wrap     <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (cfg_update) begin
        shd_div <= div_val;
        shd_res <= res_val;
        pend    <= 1'b1;
      end
      if (clear) begin
        tick_cnt <= '0;
        phase    <= '0;
        extra    <= 1'b0;
        count    <= '0;
        if (load_now) begin
          act_div <= load_div;
          act_res <= load_res;
          pend    <= 1'b0;
        end
      end else if (run) begin
        if (last) begin
          tick_cnt <= '0;
          phase    <= phase_nxt;
          extra    <= carry;
          count    <= at_top ? '0 : count + CNT_W'(1);
          wrap     <= at_top;
          if (load_now) begin
            act_div <= load_div;
            act_res <= load_res;
            pend    <= 1'b0;
          end
        end else begin
          tick_cnt <= tick_cnt + (INT_W+1)'(1);
        end
      end
    end
  end

endmodule

// File: rtl/frac_pwm_timer_chk.sv
module frac_pwm_timer_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_tick,
  input logic             ref_tick,
  input logic             src_sel,
  input logic             pause,
  input logic             clear,
  input logic [CNT_W-1:0] count,
  input logic             wrap
);

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !clear) |=> (count == $past(count) && !wrap)); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && !wrap)); // R9

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (count == '0)); // R6

  AST_WRAP_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> ($past(count) != '0)); // R6

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count == $past(count) || count == $past(count) + CNT_W'(1) || count == '0)); // R10

  AST_NO_SOURCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(src_sel ? ref_tick : slow_tick)) |=> (count == $past(count) && !wrap)); // R2

endmodule

bind frac_pwm_timer frac_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ref_tick(ref_tick),
  .src_sel(src_sel), .pause(pause), .clear(clear), .count(count), .wrap(wrap)
);

// File: tb/frac_pwm_timer_tb.sv
`timescale 1ns/1ps
module frac_pwm_timer_tb;
  localparam int INT_W = 3, FRAC_W = 4, RES_W = 3, MAX_RES = 6, INIT_RES = 2;
  localparam int DIV_W = INT_W + FRAC_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_tick = 1'b0, ref_tick = 1'b0, src_sel = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic [RES_W-1:0] res_val = '0;
  logic cfg_update = 1'b0, pause = 1'b0, clear = 1'b0;
  logic [MAX_RES-1:0] count;
  logic wrap;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  frac_pwm_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RES_W(RES_W),
                   .MAX_RES(MAX_RES), .INIT_RES(INIT_RES)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ref_tick(ref_tick),
    .src_sel(src_sel), .div_val(div_val), .res_val(res_val),
    .cfg_update(cfg_update), .pause(pause), .clear(clear),
    .count(count), .wrap(wrap));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_cfg(input int d, input int r);
    slow_tick = 1'b0; ref_tick = 1'b0;
    div_val = DIV_W'(d); res_val = RES_W'(r);
    cfg_update = 1'b1; clear = 1'b1;
    cyc();
    cfg_update = 1'b0; clear = 1'b0;
  endtask

  function automatic int exp_tick(input int d, input int k);
    int i, f;
    i = d >> FRAC_W;
    f = d & ((1 << FRAC_W) - 1);
    if (i == 0) begin i = 1; f = 0; end
    return k * i + ((k - 1) * f) / (1 << FRAC_W);
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(count == 0, "R1 reset count", int'(count), 0);
    check(wrap == 0, "R1 reset wrap", int'(wrap), 0);
    rst_n = 1'b1;
    cyc();
    slow_tick = 1'b1;
    for (int e = 1; e <= 8; e++) begin
      cyc();
      check(int'(count) == e % 4, "R1 default div 1.0 res INIT_RES", int'(count), e % 4);
      check(wrap == (e % 4 == 0), "R6 wrap default", int'(wrap), int'(e % 4 == 0));
    end

    // R3 R4 R6: full divisor sweep with resolution 1
    for (int d = 0; d < (1 << DIV_W); d++) begin
      int k, prev, nexp;
      load_cfg(d, 1);
      slow_tick = 1'b1;
      k = 0; prev = 0;
      for (int e = 1; e <= 100; e++) begin
        cyc();
        if (int'(count) != prev) begin
          k++;
          check(e == exp_tick(d, k), (d < 16) ? "R4 divided tick time" : "R3 divided tick time",
                e, exp_tick(d, k));
          check(wrap == (count == 0), "R6 wrap on return to 0", int'(wrap), int'(count == 0));
          prev = int'(count);
        end else begin
          check(wrap == 0, "R6 wrap idle", int'(wrap), 0);
        end
      end
      nexp = 0;
      while (exp_tick(d, nexp + 1) <= 100) nexp++;
      check(k == nexp, "R3 divided tick count", k, nexp);
    end

    // R5: resolution values including clamps
    for (int r = 0; r < (1 << RES_W); r++) begin
      int re, m;
      re = (r == 0) ? 1 : (r > MAX_RES ? MAX_RES : r);
      m = 1 << re;
      load_cfg(16, r);
      slow_tick = 1'b1;
      for (int e = 1; e <= m + 2; e++) begin
        cyc();
        check(int'(count) == e % m, "R5 count range", int'(count), e % m);
        check(wrap == (e % m == 0), "R6 wrap at top", int'(wrap), int'(e % m == 0));
      end
    end

    // R2: source select
    load_cfg(16, 3);
    src_sel = 1'b1; slow_tick = 1'b1; ref_tick = 1'b0;
    for (int e = 1; e <= 5; e++) cyc();
    check(count == 0, "R2 unselected slow ignored", int'(count), 0);
    slow_tick = 1'b0;
    for (int e = 1; e <= 6; e++) begin
      ref_tick = (e % 2 == 1);
      cyc();
      check(int'(count) == (e + 1) / 2, "R2 reference ticks counted", int'(count), (e + 1) / 2);
    end
    ref_tick = 1'b1; src_sel = 1'b0;
    for (int e = 1; e <= 3; e++) cyc();
    check(count == 3, "R2 unselected reference ignored", int'(count), 3);
    ref_tick = 1'b0; slow_tick = 1'b1;
    cyc();
    check(count == 4, "R2 slow counted", int'(count), 4);

    // R7: shadow values deferred to end of period
    load_cfg(64, 3);
    slow_tick = 1'b1;
    for (int e = 1; e <= 16; e++) begin
      int ex;
      if (e == 2) div_val = DIV_W'(16);
      if (e == 10) begin div_val = DIV_W'(32); cfg_update = 1'b1; end
      cyc();
      cfg_update = 1'b0;
      ex = (e >= 4) + (e >= 8) + (e >= 12) + (e >= 14) + (e >= 16);
      check(int'(count) == ex, "R7 deferred update", int'(count), ex);
    end

    // R8: pause in mid period
    load_cfg(48, 3);
    slow_tick = 1'b1;
    begin
      int n;
      n = 0;
      for (int e = 1; e <= 15; e++) begin
        pause = (e >= 5 && e <= 9);
        cyc();
        if (!pause) n++;
        check(int'(count) == n / 3, "R8 pause holds count and divider", int'(count), n / 3);
        check(wrap == 0, "R8 no wrap", int'(wrap), 0);
      end
    end
    pause = 1'b0;

    // R9: clear over pause
    clear = 1'b1; pause = 1'b1;
    cyc();
    check(count == 0, "R9 clear beats pause", int'(count), 0);
    clear = 1'b0;
    cyc();
    check(count == 0, "R9 paused after clear", int'(count), 0);
    pause = 1'b0;

    // R9: clear resets phase accumulator
    load_cfg(24, 3);
    slow_tick = 1'b1;
    for (int e = 1; e <= 3; e++) cyc();
    clear = 1'b1;
    cyc();
    clear = 1'b0;
    for (int e = 1; e <= 4; e++) begin
      int ex;
      cyc();
      ex = (e >= 1) + (e >= 2) + (e >= 4);
      check(int'(count) == ex, "R9 phase cleared", int'(count), ex);
    end

    // R9: pending update loaded by clear
    slow_tick = 1'b0;
    div_val = DIV_W'(32); res_val = RES_W'(1); cfg_update = 1'b1;
    cyc();
    cfg_update = 1'b0; div_val = DIV_W'(16); res_val = RES_W'(3);
    clear = 1'b1;
    cyc();
    clear = 1'b0; slow_tick = 1'b1;
    for (int e = 1; e <= 4; e++) begin
      int ex;
      cyc();
      ex = (e / 2) % 2;
      check(int'(count) == ex, "R9 pending loaded on clear", int'(count), ex);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule